// File: doc/BRIEF.md
# Monitor Command Character Parser

This block sits behind a serial receiver in a small debug monitor. It takes received ASCII characters, one byte per cycle in which the valid strobe is high. It recognises two commands. The resume command is `C` followed by one mode digit. The start command is `R` followed by five upper-case hex characters and then a mode digit. The hex characters give a 20-bit start address.

When the final mode digit is accepted, the block raises a one-cycle command pulse. With it come a kind flag and two timer enable flags. The kind flag is 0 for resume and 1 for start. The mode digit selects the timers: bit 0 of its value enables timer A and bit 1 enables timer B. So `0` halts both timers, `1` runs A only, `2` runs B only and `3` runs both. A start command also loads the start address.

The address, the kind and the flags stay on the outputs until the next command is issued. A malformed command raises a one-cycle error pulse, and the parser then drops back to idle. Character reception, echo and the processor that acts on the commands are handled elsewhere.

Top module: `monitor_cmd_parser`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, `cmd_pulse` and `err_pulse` are low, and `cmd_kind`, `start_addr`, `timer_a_en` and `timer_b_en` are all zero.
- R2: The byte `C` (0x43) followed by a mode digit `0`..`3` (0x30..0x33) makes `cmd_pulse` high for exactly the cycle after the digit is accepted. In that cycle `cmd_kind`=0, `timer_a_en` = bit 0 of the digit value and `timer_b_en` = bit 1 of the digit value.
- R3: The byte `R` (0x52), five hex characters and a mode digit make `cmd_pulse` high for one cycle after the digit, with `cmd_kind`=1. `start_addr` is the hex value with the first character as the most significant nibble, and the timer flags are set as in R2.
- R4: In the address field only 0x30..0x39 (`0`..`9`, values 0..9) and 0x41..0x46 (`A`..`F`, values 10..15) are accepted. Any other byte, lower case included, makes `err_pulse` high for one cycle after that byte, with no command pulse.
- R5: In the mode digit position, any byte other than 0x30..0x33 makes `err_pulse` high for one cycle after that byte, with no command pulse.
- R6: In idle, every byte other than `C` and `R` is ignored: no pulse of either kind, and no output changes.
- R7: `start_addr` changes only on a start command. `cmd_kind` and the timer flags change only when a command is issued. A resume command leaves `start_addr` as it was, and an aborted command changes no held output.
- R8: Cycles with the valid strobe low are ignored, including cycles in the middle of a command.
- R9: After an error the parser is idle, so a command that begins on the next byte is accepted in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | The byte on `rx_byte` is valid in this cycle |
| rx_byte | input | 8 | Received ASCII character |
| cmd_pulse | output | 1 | One-cycle pulse: a command was recognised |
| cmd_kind | output | 1 | Held: 0 resume, 1 start |
| start_addr | output | 20 | Held start address of the last start command |
| timer_a_en | output | 1 | Held timer A enable |
| timer_b_en | output | 1 | Held timer B enable |
| err_pulse | output | 1 | One-cycle pulse: a command was aborted |

## Verification
Each result is registered once. The command pulse, the error pulse and the held values therefore appear in the cycle right after the clock edge that accepts the deciding byte. The bench drives each byte on a falling edge and samples all outputs on the next falling edge, which puts the sample exactly in that cycle. Where a pulse should end after one cycle, the bench samples again one falling edge later. Stall cycles between bytes are inserted so that their effect is seen only at these sample points.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RES_DIG,
    ST_ADR,
    ST_RUN_DIG
  } pstate_t;

  localparam logic KIND_RESUME = 1'b0;
  localparam logic KIND_START  = 1'b1;

  function automatic logic is_hex_char(input logic [7:0] c);
    return ((c >= 8'h30) && (c <= 8'h39)) || ((c >= 8'h41) && (c <= 8'h46));
  endfunction

  function automatic logic [3:0] hex_nibble(input logic [7:0] c);
    if (c <= 8'h39) return c[3:0];
    return c[3:0] + 4'd9;
  endfunction

  function automatic logic is_mode_char(input logic [7:0] c);
    return (c >= 8'h30) && (c <= 8'h33);
  endfunction

endpackage

// File: rtl/mcp_classify.sv
module mcp_classify
  import mcp_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_c,
  output logic       is_r,
  output logic       is_hex,
  output logic [3:0] nib,
  output logic       is_mode,
  output logic [1:0] mode
);

  always_comb begin
    is_c    = (ch == 8'h43);
    is_r    = (ch == 8'h52);
    is_hex  = is_hex_char(ch);
    nib     = hex_nibble(ch);
    is_mode = is_mode_char(ch);
    mode    = ch[1:0];
  end

endmodule

// File: rtl/mcp_fsm.sv
module mcp_fsm
  import mcp_pkg::*;
#(
  parameter int NIBBLES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              is_c,
  input  logic              is_r,
  input  logic              is_hex,
  input  logic [3:0]        nib,
  input  logic              is_mode,
  output logic              ev_resume,
  output logic              ev_start,
  output logic              ev_err,
  output logic [4*NIBBLES-1:0] shadow
);

  localparam int AW = 4 * NIBBLES;
  localparam int CW = $clog2(NIBBLES + 1);

  pstate_t        state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shadow <= '0;
    end else if (valid) begin
      case (state)
        ST_IDLE: begin
          if (is_c) begin
            state <= ST_RES_DIG;
          end else if (is_r) begin
            state  <= ST_ADR;
            cnt    <= '0;
            shadow <= '0;
          end
        end
        ST_ADR: begin
          if (is_hex) begin
            shadow <= {shadow[AW-5:0], nib};
            if (cnt == CW'(NIBBLES - 1)) state <= ST_RUN_DIG;
            else cnt <= cnt + 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ev_resume = valid && (state == ST_RES_DIG) && is_mode;
    ev_start  = valid && (state == ST_RUN_DIG) && is_mode;
    ev_err    = valid && ((((state == ST_RES_DIG) || (state == ST_RUN_DIG)) && !is_mode)
                          || ((state == ST_ADR) && !is_hex));
  end

  // R3: the nibble counter never passes the last address position
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(NIBBLES));

  // R9: any error leaves the parser idle
  assert_err_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> (state == ST_IDLE));

  // R8: without a valid byte the state does not move
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(state) && $stable(cnt) && $stable(shadow));

endmodule

// File: rtl/monitor_cmd_parser.sv
module monitor_cmd_parser
  import mcp_pkg::*;
#(
  parameter int NIBBLES = 5,
  localparam int AW = 4 * NIBBLES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          cmd_pulse,
  output logic          cmd_kind,
  output logic [AW-1:0] start_addr,
  output logic          timer_a_en,
  output logic          timer_b_en,
  output logic          err_pulse
);

  logic          is_c, is_r, is_hex, is_mode;
  logic [3:0]    nib;
  logic [1:0]    mode;
  logic          ev_resume, ev_start, ev_err, ev_cmd;
  logic [AW-1:0] shadow;

  mcp_classify u_cls (
    .ch      (rx_byte),
    .is_c    (is_c),
    .is_r    (is_r),
    .is_hex  (is_hex),
    .nib     (nib),
    .is_mode (is_mode),
    .mode    (mode)
  );

  mcp_fsm #(.NIBBLES(NIBBLES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .valid     (rx_valid),
    .is_c      (is_c),
    .is_r      (is_r),
    .is_hex    (is_hex),
    .nib       (nib),
    .is_mode   (is_mode),
    .ev_resume (ev_resume),
    .ev_start  (ev_start),
    .ev_err    (ev_err),
    .shadow    (shadow)
  );

  assign ev_cmd = ev_resume || ev_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pulse  <= 1'b0;
      cmd_kind   <= KIND_RESUME;
      start_addr <= '0;
      timer_a_en <= 1'b0;
      timer_b_en <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      cmd_pulse <= ev_cmd;
      err_pulse <= ev_err;
      if (ev_cmd) begin
        cmd_kind   <= ev_start ? KIND_START : KIND_RESUME;
        timer_a_en <= mode[0];
        timer_b_en <= mode[1];
      end
      if (ev_start) start_addr <= shadow;
    end
  end

  // R2: a command pulse lasts one cycle and follows an accepted byte
  assert_cmd_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_pulse |=> !cmd_pulse);

  assert_cmd_after_byte_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_pulse |-> $past(rx_valid));

  // R5: error and command pulses never coincide
  assert_no_err_with_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    !(cmd_pulse && err_pulse));

  // R7: the address moves only with a start command
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(start_addr) |-> (cmd_pulse && cmd_kind == KIND_START));

  // R7: the flags move only with a command
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !($stable(timer_a_en) && $stable(timer_b_en) && $stable(cmd_kind)) |-> cmd_pulse);

  // R1: outputs are clear right after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_pulse && !err_pulse && start_addr == '0 && !timer_a_en && !timer_b_en));

endmodule

// File: tb/tb_monitor_cmd_parser.sv
module tb_monitor_cmd_parser;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        cmd_pulse, cmd_kind, timer_a_en, timer_b_en, err_pulse;
  logic [19:0] start_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic        g_cmd, g_kind, g_ta, g_tb, g_err;
  logic [19:0] g_addr;

  monitor_cmd_parser dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cmd_pulse(cmd_pulse), .cmd_kind(cmd_kind), .start_addr(start_addr),
    .timer_a_en(timer_a_en), .timer_b_en(timer_b_en), .err_pulse(err_pulse)
  );

  always #10 clk = ~clk;

  function automatic bit hexok(input int c);
    if (c >= 48 && c < 58) return 1;
    if (c >= 65 && c < 71) return 1;
    return 0;
  endfunction

  function automatic int hexval(input int c);
    if (c < 58) return c - 48;
    return c - 55;
  endfunction

  function automatic logic [7:0] hexch(input int v);
    if (v < 10) return 8'(48 + v);
    return 8'(55 + v);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] ch, input int gap);
    rx_valid = 1'b1;
    rx_byte  = ch;
    @(negedge clk);
    g_cmd = cmd_pulse; g_kind = cmd_kind; g_addr = start_addr;
    g_ta = timer_a_en; g_tb = timer_b_en; g_err = err_pulse;
    rx_valid = 1'b0;
    rx_byte  = 8'hFF;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] held_addr;
    logic        held_ta, held_tb, held_kind;
    int          exp_addr;

    repeat (3) @(negedge clk);
    chk("R1 pulses", {30'd0, cmd_pulse, err_pulse}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 addr", {12'd0, start_addr}, 32'd0);
    chk("R1 flags", {29'd0, cmd_kind, timer_a_en, timer_b_en}, 32'd0);
    chk("R1 pulses after", {30'd0, cmd_pulse, err_pulse}, 32'd0);

    // R6: idle ignores everything but C and R
    for (int b = 0; b < 256; b++) begin
      if (b != 8'h43 && b != 8'h52) begin
        put(8'(b), b % 2);
        chk("R6 idle", {30'd0, g_cmd, g_err}, 32'd0);
      end
    end
    chk("R6 held", {9'd0, g_addr, g_kind, g_ta, g_tb}, 32'd0);

    // R2 / R5: resume command with every digit byte 0x30..0x39
    held_addr = 20'h0; held_ta = 0; held_tb = 0; held_kind = 0;
    for (int d = 0; d < 10; d++) begin
      put(8'h43, d % 3);
      chk("R2 no early pulse", {30'd0, g_cmd, g_err}, 32'd0);
      put(8'(48 + d), 1);
      if (d < 4) begin
        chk("R2 pulse", {30'd0, g_cmd, g_err}, 32'h2);
        chk("R2 flags", {30'd0, g_ta, g_tb}, {30'd0, d[0], d[1]});
        chk("R2 kind", {31'd0, g_kind}, 32'd0);
        held_ta = d[0]; held_tb = d[1]; held_kind = 0;
      end else begin
        chk("R5 err", {30'd0, g_cmd, g_err}, 32'h1);
        chk("R7 flags kept", {30'd0, g_ta, g_tb}, {30'd0, held_ta, held_tb});
      end
      chk("R7 resume keeps addr", {12'd0, g_addr}, {12'd0, held_addr});
      chk("R2 pulse ends", {30'd0, cmd_pulse, err_pulse}, 32'd0);
    end

    // R5: a command letter in the digit position aborts
    put(8'h43, 0); put(8'h52, 0);
    chk("R5 letter as digit", {30'd0, g_cmd, g_err}, 32'h1);
    // R9: command right after the error
    put(8'h43, 0); put(8'h33, 0);
    chk("R9 recover", {30'd0, g_cmd, g_ta, g_tb}, 32'h7);
    held_ta = 1; held_tb = 1; held_kind = 0;

    // R3 / R4 / R8: every byte at every address position
    for (int p = 0; p < 5; p++) begin
      for (int b = 0; b < 256; b++) begin
        exp_addr = 0;
        put(8'h52, b % 3);
        for (int k = 0; k < p; k++) begin
          put(hexch((b + k) % 16), (b + k) % 2);
          exp_addr = exp_addr * 16 + ((b + k) % 16);
        end
        put(8'(b), b % 2);
        if (hexok(b)) begin
          chk("R4 hex accepted", {30'd0, g_cmd, g_err}, 32'd0);
          exp_addr = exp_addr * 16 + hexval(b);
          for (int k = p + 1; k < 5; k++) begin
            put(hexch((b * 3 + k) % 16), 0);
            exp_addr = exp_addr * 16 + ((b * 3 + k) % 16);
          end
          chk("R7 addr before digit", {12'd0, g_addr}, {12'd0, held_addr});
          put(8'(48 + b % 4), 1);
          chk("R3 pulse", {30'd0, g_cmd, g_err}, 32'h2);
          chk("R3 kind", {31'd0, g_kind}, 32'd1);
          chk("R3 addr", {12'd0, g_addr}, 32'(exp_addr));
          chk("R3 flags", {30'd0, g_ta, g_tb}, {30'd0, 1'(b % 2), 1'((b / 2) % 2)});
          chk("R3 pulse ends", {31'd0, cmd_pulse}, 32'd0);
          held_addr = 20'(exp_addr); held_ta = 1'(b % 2); held_tb = 1'((b / 2) % 2);
          held_kind = 1;
        end else begin
          chk("R4 bad hex err", {30'd0, g_cmd, g_err}, 32'h1);
          chk("R7 abort keeps", {9'd0, g_addr, g_kind, g_ta, g_tb},
              {9'd0, held_addr, held_kind, held_ta, held_tb});
        end
      end
    end

    // R5: bad digit after a full address
    put(8'h52, 0);
    for (int k = 0; k < 5; k++) put(hexch(15 - k), 0);
    put(8'h34, 0);
    chk("R5 run bad digit", {30'd0, g_cmd, g_err}, 32'h1);
    chk("R7 run abort addr", {12'd0, g_addr}, {12'd0, held_addr});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule